// File: doc/BRIEF.md
# Always-On Compare Timer

This block is a free-running compare timer for a low-power domain. Everything runs on one system clock. Three tick sources arrive as single-cycle enable pulses: two oscillators and a peripheral clock. A two-level selector picks one of them. An optional prescaler divides the chosen ticks by a programmable amount plus one, and a second programmable divider then sets the rate at which the counter advances.

Software uses a simple 32-bit register bus. It loads an end value and the divider settings, then starts the counter through a command register. The same command register has a self-clearing bit that restarts the count. When the counter reaches the end value, a sticky status flag is set, a second copy of that flag appears at another offset, and a one-cycle event pulse goes out to an external interrupt controller. After a match the counter keeps running and wraps to zero at full scale.

Top module: `aon_cmp_timer`

## Requirements
- R1: Source selection uses control register 0x00. When bit 25 is 1, only `pclk_tick_i` advances the timer. When bit 25 is 0, bit 0 picks `osc1_tick_i` (1) or `osc0_tick_i` (0). Pulses on the two unselected inputs have no effect on the count.
- R2: When control bit 24 is 1, the prescaler passes one tick out of every F+1 selected ticks, where F is control bits 23:20. When bit 24 is 0, every selected tick passes and F is ignored.
- R3: The divider register at 0x74 holding N advances the counter once every N prescaled ticks. N equal to 0 is treated as 1.
- R4: The count reads at 0x78. It advances only while command register 0x6C bit 0 is 1, and it holds its value while that bit is 0. Writes to 0x78 are ignored. Bit 0 of 0x6C reads back as written.
- R5: Writing 1 to bit 1 of 0x6C clears the count, the status flag and the phase of both dividers. This clear wins over any increment in the same cycle. The bit always reads back as 0.
- R6: When the count becomes equal to the end value at 0x70, bit 0 of status 0x7C and bit 0 of the copy at 0x04 become 1 in the following cycle. In that same cycle `evt_o` is high for exactly one clock. The flag stays set, ignores writes, and clears only through R5.
- R7: After a match the counter keeps counting. From its maximum value it wraps to 0, and an end value of 0 matches on that wrap.
- R8: Control bits 17:16 store the values 0, 1 or 2. A write carrying 3 in that field leaves the field unchanged. Control bits not named in R1, R2 and R8 read as 0.
- R9: After reset, every register reads 0 and `evt_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc0_tick_i | input | 1 | Tick enable from oscillator 0 |
| osc1_tick_i | input | 1 | Tick enable from oscillator 1 |
| pclk_tick_i | input | 1 | Tick enable from the peripheral clock |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| evt_o | output | 1 | One-cycle pulse on each compare match |

## Verification
The bench sweeps every source, both prescaler states, four prescale values and four divider values, while the two unselected inputs tick on every cycle. A wrong selector would therefore show a count many times too large, and an off-by-one ratio would show a wrong quotient. A restart is tested while the prescaler is partway through its phase. A design that kept the stale phase would count one tick early. The bench also collides a restart with a live tick, so a design that let the increment win would read 1 instead of 0. The 8-bit bench counter is run through its wrap with an end value of 0. This exposes a missed match at the wrap, a flag that does not stick, and an event held longer than one cycle.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_MIRROR = 8'h04;
    localparam logic [7:0] OFS_CMD    = 8'h6C;
    localparam logic [7:0] OFS_END    = 8'h70;
    localparam logic [7:0] OFS_TDIV   = 8'h74;
    localparam logic [7:0] OFS_COUNT  = 8'h78;
    localparam logic [7:0] OFS_STAT   = 8'h7C;

    // Control bit positions
    localparam int CTL_OSC_BIT  = 0;
    localparam int CTL_SRC_BIT  = 25;
    localparam int CTL_PEN_BIT  = 24;
    localparam int CTL_PDIV_LSB = 20;
    localparam int PDIV_W       = 4;
    localparam int CTL_AUX_LSB  = 16;
    localparam int AUX_W        = 2;
    localparam logic [AUX_W-1:0] AUX_BAD = 2'd3;

    // Command bit positions
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_CLR_BIT = 1;

    typedef struct packed {
        logic              osc_sel;
        logic              src_pclk;
        logic              pre_en;
        logic [PDIV_W-1:0] pre_div;
        logic [AUX_W-1:0]  aux_div;
        logic              run;
    } ctrl_t;

endpackage

// File: rtl/aon_src_mux.sv
module aon_src_mux (
    input  logic osc0_tick_i,
    input  logic osc1_tick_i,
    input  logic pclk_tick_i,
    input  logic osc_sel_i,
    input  logic src_pclk_i,
    output logic tick_o
);
    logic osc_tick;

    always_comb begin
        osc_tick = osc_sel_i ? osc1_tick_i : osc0_tick_i;
        tick_o   = src_pclk_i ? pclk_tick_i : osc_tick;
    end
endmodule

// File: rtl/aon_prescale.sv
module aon_prescale #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [DW-1:0] div_i,
    input  logic          tick_i,
    output logic          tick_o
);
    logic [DW-1:0] ph_d, ph_q;
    logic          hit;

    always_comb begin
        hit    = (ph_q >= div_i);
        tick_o = en_i ? (tick_i && hit) : tick_i;
        ph_d   = ph_q;
        if (clr_i || !en_i) begin
            ph_d = '0;
        end else if (tick_i) begin
            ph_d = hit ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // With a ratio of two or more, two output ticks never come back to back
    assert_prescale_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && (div_i != '0)) |=> (!tick_o || !$stable(div_i) || !en_i));
endmodule

// File: rtl/aon_tick_div.sv
module aon_tick_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] div_i,
    input  logic         tick_i,
    output logic         tick_o
);
    logic [W-1:0] ph_d, ph_q;
    logic [W-1:0] lim;
    logic         hit;

    always_comb begin
        lim    = (div_i == '0) ? W'(1) : div_i;
        hit    = (ph_q >= lim - 1'b1);
        tick_o = tick_i && hit;
        ph_d   = ph_q;
        if (clr_i) begin
            ph_d = '0;
        end else if (tick_i) begin
            ph_d = hit ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // A setting of 0 or 1 lets every tick through once the phase has settled
    assert_div_unity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_i <= W'(1)) && $stable(div_i)) |=> (!tick_i || tick_o || !$stable(div_i)));
endmodule

// File: rtl/aon_cmp_cnt.sv
module aon_cmp_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] end_i,
    output logic [W-1:0] cnt_o,
    output logic         sts_o,
    output logic         evt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         sts;
        logic         evt;
    } cstate_t;

    cstate_t s_d, s_q;
    logic [W-1:0] nxt;

    always_comb begin
        nxt     = s_q.cnt + 1'b1;
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (clr_i) begin
            s_d.cnt = '0;
            s_d.sts = 1'b0;
        end else if (inc_i) begin
            s_d.cnt = nxt;
            if (nxt == end_i) begin
                s_d.sts = 1'b1;
                s_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign sts_o = s_q.sts;
    assign evt_o = s_q.evt;

    assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((cnt_o == '0) && !sts_o && !evt_o));
    assert_evt_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> sts_o);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !clr_i) |=> sts_o);
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_o));
    assert_step_and_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/aon_cmp_timer.sv
module aon_cmp_timer
    import aon_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc0_tick_i,
    input  logic        osc1_tick_i,
    input  logic        pclk_tick_i,
    input  logic [7:0]  bus_addr_i,
    input  logic        bus_wr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        evt_o
);
    typedef struct packed {
        ctrl_t            ctl;
        logic [CNT_W-1:0] end_val;
        logic [DIV_W-1:0] tdiv;
    } regs_t;

    regs_t r_d, r_q;

    logic             clr;
    logic             sel_tick, gated_tick, pre_tick, cnt_tick;
    logic [CNT_W-1:0] cnt;
    logic             sts;
    logic [31:0]      ctl_rd;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    // Register write path
    always_comb begin
        r_d = r_q;
        clr = bus_wr_i && (bus_addr_i == OFS_CMD) && bus_wdata_i[CMD_CLR_BIT];
        if (bus_wr_i) begin
            case (bus_addr_i)
                OFS_CTRL: begin
                    r_d.ctl.osc_sel  = bus_wdata_i[CTL_OSC_BIT];
                    r_d.ctl.src_pclk = bus_wdata_i[CTL_SRC_BIT];
                    r_d.ctl.pre_en   = bus_wdata_i[CTL_PEN_BIT];
                    r_d.ctl.pre_div  = bus_wdata_i[CTL_PDIV_LSB +: PDIV_W];
                    if (bus_wdata_i[CTL_AUX_LSB +: AUX_W] != AUX_BAD)
                        r_d.ctl.aux_div = bus_wdata_i[CTL_AUX_LSB +: AUX_W];
                end
                OFS_CMD:  r_d.ctl.run = bus_wdata_i[CMD_RUN_BIT];
                OFS_END:  r_d.end_val = bus_wdata_i[CNT_W-1:0];
                OFS_TDIV: r_d.tdiv    = bus_wdata_i[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Tick chain
    aon_src_mux u_mux (
        .osc0_tick_i (osc0_tick_i),
        .osc1_tick_i (osc1_tick_i),
        .pclk_tick_i (pclk_tick_i),
        .osc_sel_i   (r_q.ctl.osc_sel),
        .src_pclk_i  (r_q.ctl.src_pclk),
        .tick_o      (sel_tick)
    );

    assign gated_tick = sel_tick && r_q.ctl.run && !clr;

    aon_prescale #(.DW(PDIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (r_q.ctl.pre_en),
        .div_i  (r_q.ctl.pre_div),
        .tick_i (gated_tick),
        .tick_o (pre_tick)
    );

    aon_tick_div #(.W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .div_i  (r_q.tdiv),
        .tick_i (pre_tick),
        .tick_o (cnt_tick)
    );

    aon_cmp_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (cnt_tick),
        .end_i (r_q.end_val),
        .cnt_o (cnt),
        .sts_o (sts),
        .evt_o (evt_o)
    );

    // Read path
    always_comb begin
        ctl_rd                            = '0;
        ctl_rd[CTL_OSC_BIT]               = r_q.ctl.osc_sel;
        ctl_rd[CTL_SRC_BIT]               = r_q.ctl.src_pclk;
        ctl_rd[CTL_PEN_BIT]               = r_q.ctl.pre_en;
        ctl_rd[CTL_PDIV_LSB +: PDIV_W]    = r_q.ctl.pre_div;
        ctl_rd[CTL_AUX_LSB +: AUX_W]      = r_q.ctl.aux_div;
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_CTRL:   bus_rdata_o = ctl_rd;
            OFS_MIRROR: bus_rdata_o[0] = sts;
            OFS_CMD:    bus_rdata_o[CMD_RUN_BIT] = r_q.ctl.run;
            OFS_END:    bus_rdata_o[CNT_W-1:0] = r_q.end_val;
            OFS_TDIV:   bus_rdata_o[DIV_W-1:0] = r_q.tdiv;
            OFS_COUNT:  bus_rdata_o[CNT_W-1:0] = cnt;
            OFS_STAT:   bus_rdata_o[0] = sts;
            default:    ;
        endcase
    end

    assert_aux_never_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl.aux_div != AUX_BAD);
    assert_stopped_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ctl.run |-> !cnt_tick);
    assert_tick_needs_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> (osc0_tick_i || osc1_tick_i || pclk_tick_i));
endmodule

// File: tb/aon_cmp_timer_tb_top.sv
module aon_cmp_timer_tb_top;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t0 = 1'b0, t1 = 1'b0, tp = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt;

    int errors = 0;
    int checks = 0;
    int evt_total = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aon_cmp_timer #(.CNT_W(CW), .DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .osc0_tick_i(t0), .osc1_tick_i(t1), .pclk_tick_i(tp),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .evt_o(evt)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (evt && rst_n) evt_total <= evt_total + 1;
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Pulse source s (0 osc0, 1 osc1, 2 pclk) n times; the other two tick every cycle
    task automatic pulse(input int s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            t0 = 1'b1; t1 = 1'b1; tp = 1'b1;
            @(negedge clk);
            t0 = (s != 0); t1 = (s != 1); tp = (s != 2);
        end
        @(negedge clk);
        t0 = 1'b0; t1 = 1'b0; tp = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] ctl_val(input int s, input int pe, input int pd);
        logic [31:0] v = '0;
        v[0]     = (s == 1);
        v[25]    = (s == 2);
        v[24]    = pe[0];
        v[23:20] = pd[3:0];
        return v;
    endfunction

    logic [31:0] d;
    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rreg(8'h00, d); chk("R9 ctrl", d, 0);
        rreg(8'h04, d); chk("R9 mirror", d, 0);
        rreg(8'h6C, d); chk("R9 cmd", d, 0);
        rreg(8'h70, d); chk("R9 end", d, 0);
        rreg(8'h74, d); chk("R9 tdiv", d, 0);
        rreg(8'h78, d); chk("R9 count", d, 0);
        rreg(8'h7C, d); chk("R9 status", d, 0);
        chk("R9 evt", {31'd0, evt}, 0);

        // R8 auxiliary field and reserved bits
        wreg(8'h00, 32'h0002_0000 | 32'h20);
        rreg(8'h00, d); chk("R8 aux=2 stored, bit5 reads 0", d, 32'h0002_0000);
        wreg(8'h00, 32'h0003_0000 | 32'h0100_0000);
        rreg(8'h00, d); chk("R8 aux=3 rejected", d, 32'h0102_0000);
        wreg(8'h00, 32'h0001_0000);
        rreg(8'h00, d); chk("R8 aux=1 stored", d, 32'h0001_0000);

        // R1 R2 R3 sweep
        wreg(8'h70, 32'hFF);
        base = evt_total;
        for (int s = 0; s < 3; s++)
            for (int pe = 0; pe < 2; pe++)
                for (int pd = 0; pd < 4; pd++)
                    for (int td = 0; td < 4; td++) begin
                        int p, dv, k;
                        p  = pe ? pd + 1 : 1;
                        dv = (td == 0) ? 1 : td;
                        k  = 12 + s;
                        wreg(8'h00, ctl_val(s, pe, pd));
                        wreg(8'h74, td);
                        wreg(8'h6C, 32'h3);
                        pulse(s, k);
                        rreg(8'h78, d);
                        chk($sformatf("R1 R2 R3 src=%0d pe=%0d pd=%0d td=%0d", s, pe, pd, td),
                            d, k / (p * dv));
                    end
        chk("R6 no event below end", evt_total - base, 0);

        // R4 run/stop, count read-only
        wreg(8'h00, 0); wreg(8'h74, 1);
        wreg(8'h6C, 32'h3);
        rreg(8'h6C, d); chk("R5 clear bit reads 0, R4 run reads 1", d, 1);
        pulse(0, 4);
        rreg(8'h78, d); chk("R4 running count", d, 4);
        wreg(8'h6C, 0);
        pulse(0, 5);
        rreg(8'h78, d); chk("R4 stopped holds", d, 4);
        wreg(8'h78, 32'h55);
        rreg(8'h78, d); chk("R4 count write ignored", d, 4);
        wreg(8'h6C, 1);
        pulse(0, 2);
        rreg(8'h78, d); chk("R4 resumed", d, 6);

        // R5 clear beats a simultaneous tick
        @(negedge clk);
        t0 = 1'b1; addr = 8'h6C; wdata = 32'h3; wr = 1'b1;
        @(negedge clk);
        t0 = 1'b0; wr = 1'b0; wdata = '0;
        rreg(8'h78, d); chk("R5 clear priority", d, 0);
        pulse(0, 2);
        rreg(8'h78, d); chk("R5 counts after clear", d, 2);

        // R5 clear restarts prescaler phase
        wreg(8'h00, ctl_val(0, 1, 1));
        wreg(8'h6C, 32'h3);
        pulse(0, 1);
        wreg(8'h6C, 32'h3);
        pulse(0, 1);
        rreg(8'h78, d); chk("R5 phase restarted", d, 0);
        pulse(0, 1);
        rreg(8'h78, d); chk("R5 full ratio after restart", d, 1);

        // R6 match, sticky flag, one-cycle event
        wreg(8'h00, 0);
        wreg(8'h70, 6);
        wreg(8'h6C, 32'h3);
        base = evt_total;
        pulse(0, 5);
        rreg(8'h7C, d); chk("R6 no flag before end", d, 0);
        pulse(0, 1);
        rreg(8'h7C, d); chk("R6 status set", d, 1);
        rreg(8'h04, d); chk("R6 mirror set", d, 1);
        chk("R6 one event cycle", evt_total - base, 1);
        pulse(0, 3);
        rreg(8'h78, d); chk("R7 keeps counting", d, 9);
        wreg(8'h7C, 0);
        rreg(8'h7C, d); chk("R6 status sticky", d, 1);
        chk("R6 still one event", evt_total - base, 1);
        wreg(8'h6C, 32'h3);
        rreg(8'h7C, d); chk("R5 status cleared", d, 0);
        rreg(8'h04, d); chk("R5 mirror cleared", d, 0);

        // R7 wrap with end value 0
        wreg(8'h70, 0);
        wreg(8'h6C, 32'h3);
        base = evt_total;
        pulse(0, 255);
        rreg(8'h78, d); chk("R7 at max", d, 255);
        chk("R7 no event before wrap", evt_total - base, 0);
        pulse(0, 1);
        rreg(8'h78, d); chk("R7 wrapped", d, 0);
        rreg(8'h7C, d); chk("R7 match on wrap", d, 1);
        chk("R7 event on wrap", evt_total - base, 1);
        pulse(0, 2);
        rreg(8'h78, d); chk("R7 after wrap", d, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule